// File: doc/BRIEF.md
# Static RAM Interconnect Test Sequencer

This block is a synthesizable controller that checks the wiring and basic operation of an external asynchronous static RAM. The RAM has 2048 words of 8 bits, an 11-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip enable, write enable and output enable. A single `start_i` pulse runs a fixed program of 85 steps. The program has four parts:

- a write/read check of each data line on its own at address 0;
- two full passes of paired data patterns over a thermometer-coded address set;
- a check that a write with chip enable high does not reach the array;
- a check that the bus floats to its pull-up level when output enable is high.

The bidirectional data bus is split at the block boundary. `data_o` carries the value to drive and `data_oe_o` gives a drive enable for each bit. The resolved bus value comes back on `data_i`, and the pad ring combines these signals. Each step is built from phases of fixed length, `CYC_CLKS` clocks each. A read step samples the bus `SAMPLE_CLKS` clocks into its data phase.

The program stops at the first miscompare. It then holds `done_o` and `fail_o` high and latches three values: the step index, the expected byte and the observed byte. If every step matches, `done_o` rises with `fail_o` low.

Top module: `sram_tst`

## Requirements
- R1: While not running (after reset, before a start, and after completion), the bus is parked: `ce_no`=1, `we_no`=1, `oe_no`=0 and `data_oe_o`=0. Reset clears `done_o` and `fail_o` to 0.
- R2: Steps 0..31 test each data line b from 0 to 7 at address 0, in this order: step 4b writes 0, step 4b+1 reads, step 4b+2 writes 1, step 4b+3 reads. Only bit b is driven (`data_oe_o` = 1<<b), and only bit b is compared.
- R3: The address set is the 12 thermometer codes (2^k)-1 for k=0..11, in increasing k. Steps 32..43 write the bytes 00,11,33,77,FF,E7,C3,81,A5,24,66,5A to these addresses in order. Steps 44..55 then read them back in the same order and compare all 8 bits.
- R4: Steps 56..67 write FF,E7,C3,81,00,11,33,77,5A,DB,99,A5 to the same addresses in the same order. Steps 68..79 then read and compare them.
- R5: Step 80 writes 00 to address 0. Step 81 drives AA with `we_no`=0 while `ce_no` stays 1. Step 82 reads address 0 and expects 00.
- R6: Step 83 writes 00 to address 0. Step 84 reads address 0 with `ce_no`=0 and `oe_no`=1 and expects FF from the pulled-up bus.
- R7: Every phase lasts `CYC_CLKS` clocks.
  - A write step has three phases:
    - address phase: `ce_no`=0, `we_no`=1, no drive;
    - data phase: `we_no`=0, data driven;
    - rest phase: idle levels.
  - A read step has two phases, an address phase and a data phase, with `we_no`=1. The bus is sampled on the `SAMPLE_CLKS`-th clock of the data phase.
- R8: `data_oe_o` is nonzero only while `we_no`=0 and `oe_no`=1. It is zero in the clock before any clock that has `ce_no`=0, `we_no`=1 and `oe_no`=0.
- R9: On the first miscompare the program stops in the clock after the sample. `done_o` and `fail_o` go high. `fail_step_o` holds the step index. `fail_exp_o` and `fail_got_o` hold the expected and observed bytes ANDed with the compare mask. The bus returns to the R1 idle levels.
- R10: With no miscompare, `done_o` rises with `fail_o`=0 exactly 213·`CYC_CLKS` clocks after the clock edge that accepts start.
- R11: A start pulse while running is ignored. A start pulse while idle or done relaunches the program from step 0 and clears `done_o` and `fail_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous start pulse |
| addr_o | output | 11 | RAM address |
| data_o | output | 8 | Value to drive onto the data bus |
| data_oe_o | output | 8 | Per-bit drive enable for the data bus |
| data_i | input | 8 | Resolved data bus value |
| ce_no | output | 1 | Chip enable, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| done_o | output | 1 | Program finished (pass or fail) |
| fail_o | output | 1 | A miscompare occurred |
| fail_step_o | output | 7 | Index of the first failing step |
| fail_exp_o | output | 8 | Expected byte at the failure, masked |
| fail_got_o | output | 8 | Observed byte at the failure, masked |

## Verification
The strobe and drive outputs are decoded from registered state, so they change on the clock edge that enters each phase. The bench counts clock edges from the edge that accepts start and checks the levels at the falling edge of the clocks `CYC_CLKS` apart. `done_o` is due one edge after the deciding event:

| Outcome | Deciding event | Edges after the start edge |
|---|---|---|
| Miscompare | Sampling clock of the failing step | (whole phases before the failing data phase)·`CYC_CLKS` + `SAMPLE_CLKS` |
| Clean run | Last phase ends | 213·`CYC_CLKS` |

Each injected RAM fault is placed so that the step where it must first appear is known in advance. The bench compares the measured edge count against these formulas exactly, so a late or early stop is a failure.

// File: rtl/sram_tst_pkg.sv
package sram_tst_pkg;
  localparam int ADDR_W     = 11;
  localparam int DATA_W     = 8;
  localparam int PAT_LEN    = ADDR_W + 1;
  localparam int BIT_STEPS  = 4 * DATA_W;
  localparam int PASS_STEPS = 2 * PAT_LEN;
  localparam int CS_BASE    = BIT_STEPS + 2 * PASS_STEPS;
  localparam int OE_BASE    = CS_BASE + 3;
  localparam int NUM_STEPS  = OE_BASE + 2;
  localparam int STEP_W     = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_WR_NOCS, OP_RD_NOOE} op_kind_e;
  typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_REST} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  typedef struct packed {
    op_kind_e            kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic [DATA_W-1:0]   mask;
  } op_t;

  function automatic logic [DATA_W-1:0] pat_first(int k);
    case (k)
      0: return 8'h00;  1: return 8'h11;  2: return 8'h33;  3: return 8'h77;
      4: return 8'hFF;  5: return 8'hE7;  6: return 8'hC3;  7: return 8'h81;
      8: return 8'hA5;  9: return 8'h24; 10: return 8'h66; 11: return 8'h5A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pat_second(int k);
    case (k)
      0: return 8'hFF;  1: return 8'hE7;  2: return 8'hC3;  3: return 8'h81;
      4: return 8'h00;  5: return 8'h11;  6: return 8'h33;  7: return 8'h77;
      8: return 8'h5A;  9: return 8'hDB; 10: return 8'h99; 11: return 8'hA5;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] therm(int k);
    logic [ADDR_W:0] t;
    t = ((ADDR_W+1)'(1) << k) - (ADDR_W+1)'(1);
    return t[ADDR_W-1:0];
  endfunction

  function automatic op_t decode_step(logic [STEP_W-1:0] s);
    op_t o;
    int  i, r, k;
    i      = int'(s);
    o.kind = OP_WR;
    o.addr = '0;
    o.data = '0;
    o.mask = '1;
    if (i < BIT_STEPS) begin
      o.mask = DATA_W'(1) << (i / 4);
      o.kind = (i % 2 == 1) ? OP_RD : OP_WR;
      o.data = ((i / 2) % 2 == 1) ? o.mask : '0;
    end else if (i < CS_BASE) begin
      r      = i - BIT_STEPS;
      k      = r % PAT_LEN;
      o.addr = therm(k);
      o.kind = ((r / PAT_LEN) % 2 == 1) ? OP_RD : OP_WR;
      o.data = (r >= PASS_STEPS) ? pat_second(k) : pat_first(k);
    end else begin
      case (i - CS_BASE)
        0:       o.kind = OP_WR;
        1:       begin o.kind = OP_WR_NOCS; o.data = 8'hAA; end
        2:       o.kind = OP_RD;
        3:       o.kind = OP_WR;
        default: begin o.kind = OP_RD_NOOE; o.data = '1; end
      endcase
    end
    return o;
  endfunction
endpackage

// File: rtl/sram_tst_timer.sv
module sram_tst_timer #(
  parameter int CYC_CLKS    = 50,
  parameter int SAMPLE_CLKS = 37
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic last_o,
  output logic sample_o
);
  localparam int CNT_W = $clog2(CYC_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYC_CLKS - 1);
  localparam logic [CNT_W-1:0] SMP_CNT  = CNT_W'(SAMPLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o   = run_i && (cnt_q == LAST_CNT);
  assign sample_o = run_i && (cnt_q == SMP_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sram_tst_step_rom.sv
module sram_tst_step_rom
  import sram_tst_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output op_t               op_o
);
  assign op_o = decode_step(step_i);
endmodule

// File: rtl/sram_tst_cmp.sv
module sram_tst_cmp #(
  parameter int DATA_W = 8,
  parameter int STEP_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              miss_o,
  output logic              fail_o,
  output logic [STEP_W-1:0] fail_step_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  assign miss_o = sample_i && (((data_i ^ exp_i) & mask_i) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_step_o <= '0;
      fail_exp_o  <= '0;
      fail_got_o  <= '0;
    end else if (clear_i) begin
      fail_o      <= 1'b0;
      fail_step_o <= '0;
      fail_exp_o  <= '0;
      fail_got_o  <= '0;
    end else if (miss_o) begin
      fail_o      <= 1'b1;
      fail_step_o <= step_i;
      fail_exp_o  <= exp_i & mask_i;
      fail_got_o  <= data_i & mask_i;
    end
  end
endmodule

// File: rtl/sram_tst.sv
module sram_tst
  import sram_tst_pkg::*;
#(
  parameter int CYC_CLKS    = 50,
  parameter int SAMPLE_CLKS = 37
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              ce_no,
  output logic              we_no,
  output logic              oe_no,
  output logic              done_o,
  output logic              fail_o,
  output logic [STEP_W-1:0] fail_step_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  state_e            state_q;
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  op_t               op;
  logic              running, start_ok, is_rd, tick_last, tick_smp;
  logic              sample_rd, miss, op_end;

  assign running  = (state_q == ST_RUN);
  assign start_ok = start_i && !running;
  assign is_rd    = (op.kind == OP_RD) || (op.kind == OP_RD_NOOE);

  sram_tst_timer #(
    .CYC_CLKS   (CYC_CLKS),
    .SAMPLE_CLKS(SAMPLE_CLKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_ok),
    .run_i   (running),
    .last_o  (tick_last),
    .sample_o(tick_smp)
  );

  sram_tst_step_rom u_rom (
    .step_i(step_q),
    .op_o  (op)
  );

  assign sample_rd = running && (phase_q == PH_DATA) && is_rd && tick_smp;

  sram_tst_cmp #(
    .DATA_W(DATA_W),
    .STEP_W(STEP_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ok),
    .sample_i   (sample_rd),
    .step_i     (step_q),
    .exp_i      (op.data),
    .mask_i     (op.mask),
    .data_i     (data_i),
    .miss_o     (miss),
    .fail_o     (fail_o),
    .fail_step_o(fail_step_o),
    .fail_exp_o (fail_exp_o),
    .fail_got_o (fail_got_o)
  );

  // a read ends after its data phase, a write after its rest phase
  assign op_end = tick_last &&
                  (((phase_q == PH_DATA) && is_rd) || (phase_q == PH_REST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      step_q  <= '0;
    end else if (start_ok) begin
      state_q <= ST_RUN;
      phase_q <= PH_ADDR;
      step_q  <= '0;
    end else if (running) begin
      if (miss) begin
        state_q <= ST_DONE;
      end else if (op_end) begin
        phase_q <= PH_ADDR;
        if (step_q == LAST_STEP) state_q <= ST_DONE;
        else                     step_q  <= step_q + STEP_W'(1);
      end else if (tick_last) begin
        phase_q <= (phase_q == PH_ADDR) ? PH_DATA : PH_REST;
      end
    end
  end

  always_comb begin
    ce_no     = 1'b1;
    we_no     = 1'b1;
    oe_no     = 1'b0;
    data_oe_o = '0;
    data_o    = '0;
    addr_o    = '0;
    if (running) begin
      addr_o = op.addr;
      if (phase_q != PH_REST) begin
        unique case (op.kind)
          OP_WR, OP_WR_NOCS: begin
            ce_no = (op.kind == OP_WR_NOCS);
            oe_no = 1'b1;
            if (phase_q == PH_DATA) begin
              we_no     = 1'b0;
              data_oe_o = op.mask;
              data_o    = op.data & op.mask;
            end
          end
          OP_RD, OP_RD_NOOE: begin
            ce_no = 1'b0;
            oe_no = (op.kind == OP_RD_NOOE);
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sram_tst_chk.sv
module sram_tst_chk #(
  parameter int DATA_W    = 8,
  parameter int STEP_W    = 7,
  parameter int NUM_STEPS = 85
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ce_no,
  input logic              we_no,
  input logic              oe_no,
  input logic [DATA_W-1:0] data_oe_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [STEP_W-1:0] fail_step_o
);
  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0) |-> (!we_no && oe_no)); // R8

  AST_DRIVE_GAP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && we_no && !oe_no) |-> ($past(data_oe_o) == '0)); // R8

  AST_FAIL_IMPLIES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o); // R9

  AST_DONE_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ce_no && we_no && !oe_no && (data_oe_o == '0))); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_step_o))); // R9

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && !fail_o)); // R11

  AST_STEP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (int'(fail_step_o) < NUM_STEPS)); // R9
endmodule

bind sram_tst sram_tst_chk #(
  .DATA_W   (sram_tst_pkg::DATA_W),
  .STEP_W   (sram_tst_pkg::STEP_W),
  .NUM_STEPS(sram_tst_pkg::NUM_STEPS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ce_no      (ce_no),
  .we_no      (we_no),
  .oe_no      (oe_no),
  .data_oe_o  (data_oe_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .fail_step_o(fail_step_o)
);

// File: tb/sram_tst_tb.sv
module sram_tst_tb;
  import sram_tst_pkg::*;

  localparam int CYC      = 10;
  localparam int SMP      = 7;
  localparam int TOTAL_PH = 213;
  localparam logic [7:0] TB_PA [12] = '{8'h00, 8'h11, 8'h33, 8'h77, 8'hFF, 8'hE7,
                                         8'hC3, 8'h81, 8'hA5, 8'h24, 8'h66, 8'h5A};
  localparam logic [7:0] TB_PB [12] = '{8'hFF, 8'hE7, 8'hC3, 8'h81, 8'h00, 8'h11,
                                         8'h33, 8'h77, 8'h5A, 8'hDB, 8'h99, 8'hA5};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] data_o, data_oe_o, data_i;
  logic              ce_no, we_no, oe_no, done_o, fail_o;
  logic [STEP_W-1:0] fail_step_o;
  logic [DATA_W-1:0] fail_exp_o, fail_got_o;

  int n_chk = 0;
  int n_fail = 0;
  int fault = 0; // 1 bit3 low everywhere, 2 bit1 low at addr 3, 3 bit6 high at addr 7FF, 4 ce ignored, 5 oe ignored

  always #4 clk_i = ~clk_i;

  sram_tst #(.CYC_CLKS(CYC), .SAMPLE_CLKS(SMP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_o(addr_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .data_i(data_i), .ce_no(ce_no),
    .we_no(we_no), .oe_no(oe_no), .done_o(done_o), .fail_o(fail_o),
    .fail_step_o(fail_step_o), .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o)
  );

  // RAM model with pull-ups and injectable faults
  logic [7:0] mem [0:2047];
  logic [7:0] ram_rd;
  logic       ram_en;
  always_comb begin
    ram_rd = mem[addr_o];
    case (fault)
      1: ram_rd[3] = 1'b0;
      2: if (addr_o == 11'd3) ram_rd[1] = 1'b0;
      3: if (addr_o == 11'h7FF) ram_rd[6] = 1'b1;
      default: ;
    endcase
  end
  assign ram_en = !ce_no && we_no && (!oe_no || fault == 5);
  always_comb
    for (int b = 0; b < 8; b++)
      data_i[b] = data_oe_o[b] ? data_o[b] : (ram_en ? ram_rd[b] : 1'b1);
  always @(posedge clk_i)
    if (!we_no && (!ce_no || fault == 4)) mem[addr_o] <= data_i;

  // bus monitor
  logic [27:0] wr_log [0:63];
  int          wr_n = 0;
  int          gap_viol = 0;
  logic        prev_we = 1'b1;
  logic [7:0]  prev_oe = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!we_no && prev_we && wr_n < 64) begin
        wr_log[wr_n] = {ce_no, addr_o, data_o & data_oe_o, data_oe_o};
        wr_n++;
      end
      if (!ce_no && we_no && !oe_no && prev_oe != 8'h00) gap_viol++;
      if (data_oe_o != 8'h00 && we_no) gap_viol++;
    end
    prev_we = we_no;
    prev_oe = data_oe_o;
  end

  function automatic logic [10:0] tb_therm(int j);
    logic [11:0] t;
    t = (12'd1 << j) - 12'd1;
    return t[10:0];
  endfunction

  function automatic logic [27:0] exp_wr(int k);
    logic c; logic [10:0] a; logic [7:0] d, m;
    c = 1'b0; a = '0; d = '0; m = 8'hFF;
    if (k < 16) begin
      m = 8'h01 << (k / 2);
      d = (k % 2 == 1) ? m : 8'h00;
    end else if (k < 28) begin
      a = tb_therm(k - 16); d = TB_PA[k - 16];
    end else if (k < 40) begin
      a = tb_therm(k - 28); d = TB_PB[k - 28];
    end else if (k == 41) begin
      c = 1'b1; d = 8'hAA;
    end
    return {c, a, d, m};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) start_i = 1'b0;
  endtask

  // counts edges after the start edge until done; optional start poke mid-run
  task automatic run_time(output int n, input int poke_at);
    n = 0;
    while (!done_o && n < 5000) begin
      if (n == poke_at) start_i = 1'b1;
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      start_i = 1'b0;
    end
  endtask

  task automatic check_idle(string tag);
    chk({tag, " ce_no"}, 32'(ce_no), 32'd1);
    chk({tag, " we_no"}, 32'(we_no), 32'd1);
    chk({tag, " oe_no"}, 32'(oe_no), 32'd0);
    chk({tag, " drive"}, 32'(data_oe_o), 32'd0);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 2048; a++) mem[a] = 8'h00;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset");
    chk("R1 reset done", 32'(done_o), 32'd0);
    chk("R1 reset fail", 32'(fail_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_idle("R1 idle");
  endtask

  task automatic t_phase_timing();
    int n;
    fault = 0;
    pulse_start();
    chk("R7 addr ce", 32'(ce_no), 32'd0);
    chk("R7 addr we", 32'(we_no), 32'd1);
    chk("R7 addr drive", 32'(data_oe_o), 32'd0);
    repeat (CYC - 1) @(negedge clk_i);
    chk("R7 addr end we", 32'(we_no), 32'd1);
    @(negedge clk_i);
    chk("R7 data we", 32'(we_no), 32'd0);
    chk("R2 single bit drive", 32'(data_oe_o), 32'h01);
    chk("R2 drive value", 32'(data_o), 32'h00);
    repeat (CYC - 1) @(negedge clk_i);
    chk("R7 data end we", 32'(we_no), 32'd0);
    @(negedge clk_i);
    check_idle("R7 rest");
    repeat (CYC) @(negedge clk_i);
    chk("R7 read ce", 32'(ce_no), 32'd0);
    chk("R7 read we", 32'(we_no), 32'd1);
    chk("R7 read oe", 32'(oe_no), 32'd0);
    run_time(n, -1);
  endtask

  task automatic t_pass();
    int n;
    string tg;
    fault = 0;
    wr_n = 0;
    gap_viol = 0;
    pulse_start();
    run_time(n, -1);
    chk("R10 done time", 32'(n), 32'(TOTAL_PH * CYC));
    chk("R10 done", 32'(done_o), 32'd1);
    chk("R10 fail low", 32'(fail_o), 32'd0);
    chk("R2 write count", 32'(wr_n), 32'd43);
    for (int k = 0; k < 43; k++) begin
      tg = (k < 16) ? "R2 write" : (k < 28) ? "R3 write" : (k < 40) ? "R4 write" :
           (k < 42) ? "R5 write" : "R6 write";
      chk($sformatf("%s %0d", tg, k), 32'(wr_log[k]), 32'(exp_wr(k)));
    end
    chk("R8 drive gap", 32'(gap_viol), 32'd0);
    check_idle("R1 after done");
  endtask

  task automatic t_fault(int f, string tag, int exp_n, int step, logic [7:0] ex, logic [7:0] got);
    int n;
    fault = f;
    pulse_start();
    run_time(n, -1);
    chk({tag, " stop time"}, 32'(n), 32'(exp_n));
    chk({tag, " R9 fail"}, 32'(fail_o), 32'd1);
    chk({tag, " R9 step"}, 32'(fail_step_o), 32'(step));
    chk({tag, " R9 exp"}, 32'(fail_exp_o), 32'(ex));
    chk({tag, " R9 got"}, 32'(fail_got_o), 32'(got));
    repeat (3) @(negedge clk_i);
    check_idle({tag, " R9 idle"});
    chk({tag, " R9 held"}, 32'(done_o), 32'd1);
    fault = 0;
  endtask

  task automatic t_restart();
    int n;
    // done with fail=1 from the previous test: a start relaunches and clears
    @(negedge clk_i) start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) start_i = 1'b0;
    chk("R11 restart done", 32'(done_o), 32'd0);
    chk("R11 restart fail", 32'(fail_o), 32'd0);
    run_time(n, 300);
    chk("R11 start ignored time", 32'(n), 32'(TOTAL_PH * CYC));
    chk("R11 pass after restart", 32'(fail_o), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_phase_timing();
    t_pass();
    t_fault(1, "R2", 39 * CYC + SMP, 15, 8'h08, 8'h00);
    t_fault(2, "R3", 121 * CYC + SMP, 46, 8'h33, 8'h31);
    t_fault(3, "R4", 199 * CYC + SMP, 79, 8'hA5, 8'hE5);
    t_fault(4, "R5", 207 * CYC + SMP, 82, 8'h00, 8'hAA);
    t_fault(5, "R6", 212 * CYC + SMP, 84, 8'hFF, 8'h00);
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule